// File: doc/BRIEF.md
# Data-Port Write Queue Drain

This block sits on the processor's data-port write path of a video controller. Each data-port write goes into a small ordered queue. Every entry carries the cycle count from which it may be serviced. The outside scheduler grants memory access slots. On each granted slot the block takes at most one step on the oldest entry. That step writes into one of three memories: pattern RAM, palette RAM or scroll RAM. The memory is chosen by the current command code. After each completed write the destination address advances by a programmable stride.

Pattern RAM is byte-wide, so one word needs two granted slots. The first slot writes the upper byte and marks the entry as half done. The second slot writes the lower byte at the companion address, which is the address with bit 0 inverted. Only then is the entry retired and the address advanced. When the transfer engine is enabled and the command asks for a transfer, the oldest entry is not written to memory. It is handed off as the seed value of a fill operation. The block also reports when the queue is full and when a granted slot went unused.

Top module: `wq_drain`

## Requirements
- R1: While reset is held, `queueFull`, `pushStall`, `memWe`, `fillStart` and `unusedSlot` are 0, `curAddr` is 0, and the queue is empty.
- R2: The queue holds DEPTH (4) entries. `queueFull` is 1 exactly when 4 entries are held. A push while full raises `pushStall` in that cycle and the pushed word is discarded, even when a slot retires an entry in the same cycle.
- R3: On a granted slot, the oldest entry is serviced only if the queue is non-empty and its eligibility cycle is less than or equal to `curCycle`. Otherwise `unusedSlot` is 1 in that cycle and no write, fill or address change takes place.
- R4: With `cmdCode` = 1 (pattern RAM), the first granted slot of an entry writes a byte: `memByte`=1, `memAddr`=`curAddr`, and `memData[7:0]` = bits 15:8 of the word. The entry stays and the address is unchanged. The next granted slot writes bits 7:0 at `curAddr` XOR 1, retires the entry and advances the address.
- R5: With `cmdCode` = 3 (palette RAM), one granted slot writes the whole word at `curAddr`, retires the entry and advances the address.
- R6: With `cmdCode` = 5 (scroll RAM), the word is written at `curAddr` only when address bits 6:1 are below SCROLL_WORDS (40). In both cases the entry is retired and the address advances.
- R7: Any other `cmdCode` retires the entry and advances the address without a memory write.
- R8: When `dmaEnable` and `dmaReq` are both 1, a serviced slot pulses `fillStart` with `fillValue` equal to the oldest word. The entry is retired, no memory write occurs and the address is unchanged.
- R9: Entries are serviced strictly in push order, including a push made in the same cycle as a retirement. A new entry always starts with its first pattern-RAM byte.
- R10: The address advances by `autoInc` modulo 2^ADDR_W. `addrLoad` overrides it.
- R11: Without `slotGrant`, no write, fill or unused-slot indication occurs and the address is held.
- R12: `memTarget` encodes the written memory as 1 pattern, 2 palette, 3 scroll, and is 0 when `memWe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curCycle | input | CYC_W | Current cycle count for eligibility |
| pushValid | input | 1 | Data-port write request |
| pushData | input | DATA_W | Written word |
| pushEligible | input | CYC_W | Cycle from which the entry may be serviced |
| pushStall | output | 1 | Push refused, queue full |
| queueFull | output | 1 | Queue holds DEPTH entries |
| addrLoad | input | 1 | Load a new destination address |
| addrValue | input | ADDR_W | Address to load |
| autoInc | input | INC_W | Address stride per completed write |
| cmdCode | input | 4 | Target selector (1 pattern, 3 palette, 5 scroll) |
| dmaReq | input | 1 | Command requests a transfer |
| dmaEnable | input | 1 | Transfer engine enabled |
| slotGrant | input | 1 | Memory slot granted this cycle |
| memWe | output | 1 | Memory write strobe |
| memTarget | output | 2 | Memory selected for the write |
| memByte | output | 1 | Write is a single byte in memData[7:0] |
| memAddr | output | ADDR_W | Write address |
| memData | output | DATA_W | Write data |
| fillStart | output | 1 | Fill hand-off pulse |
| fillValue | output | DATA_W | Fill seed word |
| unusedSlot | output | 1 | Granted slot not used |
| curAddr | output | ADDR_W | Current destination address |

## Verification
Every command code is swept with the transfer-request bit and the engine enable in both states. This separates the byte-pair path, the word paths, the silent retirement and the fill hand-off, and shows which of them move the address. Every even scroll address over two wraps of the 6-bit index checks the range cut at 40. A queue filled to depth shows the stall, the discarded fifth word and the push order. A push made alongside a retirement shows that the slots shift correctly. An entry whose eligibility cycle lies in the future is granted slots up to and across that cycle, which pins the exact comparison. A load near the top of the address space checks the wrap.

// File: rtl/wq_pkg.sv
package wq_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_CRAM  = 2'd2,
    TGT_VSRAM = 2'd3
  } tgt_e;

  localparam logic [3:0] CODE_VRAM  = 4'd1;
  localparam logic [3:0] CODE_CRAM  = 4'd3;
  localparam logic [3:0] CODE_VSRAM = 4'd5;

  localparam int SCROLL_IDX_W = 6;

  typedef struct packed {
    logic pop;
    logic markPartial;
    logic incAddr;
    logic wrHigh;
    logic wrLow;
    logic wrWord;
    logic startFill;
    logic unused;
    tgt_e target;
  } drainStrobe_t;

endpackage

// File: rtl/wq_ctrl.sv
module wq_ctrl
  import wq_pkg::*;
#(
  parameter int SCROLL_WORDS = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    slotGrant,
  input  logic                    headReady,
  input  logic                    headPartial,
  input  logic [3:0]              cmdCode,
  input  logic                    dmaEnable,
  input  logic                    dmaReq,
  input  logic [SCROLL_IDX_W-1:0] scrollIdx,
  output drainStrobe_t            strobe
);

  localparam logic [SCROLL_IDX_W:0] SCROLL_LIMIT = (SCROLL_IDX_W+1)'(SCROLL_WORDS);

  logic scrollInRange;
  assign scrollInRange = {1'b0, scrollIdx} < SCROLL_LIMIT;

  always_comb begin
    strobe.pop         = 1'b0;
    strobe.markPartial = 1'b0;
    strobe.incAddr     = 1'b0;
    strobe.wrHigh      = 1'b0;
    strobe.wrLow       = 1'b0;
    strobe.wrWord      = 1'b0;
    strobe.startFill   = 1'b0;
    strobe.unused      = 1'b0;
    strobe.target      = TGT_NONE;
    if (slotGrant) begin
      if (!headReady) begin
        strobe.unused = 1'b1;
      end else if (dmaEnable && dmaReq) begin
        strobe.startFill = 1'b1;
        strobe.pop       = 1'b1;
      end else begin
        unique case (cmdCode)
          CODE_VRAM: begin
            strobe.target = TGT_VRAM;
            if (headPartial) begin
              strobe.wrLow   = 1'b1;
              strobe.pop     = 1'b1;
              strobe.incAddr = 1'b1;
            end else begin
              strobe.wrHigh      = 1'b1;
              strobe.markPartial = 1'b1;
            end
          end
          CODE_CRAM: begin
            strobe.target  = TGT_CRAM;
            strobe.wrWord  = 1'b1;
            strobe.pop     = 1'b1;
            strobe.incAddr = 1'b1;
          end
          CODE_VSRAM: begin
            strobe.target  = TGT_VSRAM;
            strobe.wrWord  = scrollInRange;
            strobe.pop     = 1'b1;
            strobe.incAddr = 1'b1;
          end
          default: begin
            strobe.pop     = 1'b1;
            strobe.incAddr = 1'b1;
          end
        endcase
      end
    end
  end

  // R3: at most one kind of slot action per cycle
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.unused, strobe.wrHigh, strobe.wrLow, strobe.wrWord, strobe.startFill}));

  // R3: a granted slot with nothing eligible is reported unused
  p_unused_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    slotGrant && !headReady |-> strobe.unused && !strobe.pop);

  // R8: a fill hand-off never moves the address
  p_fill_no_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFill |-> !strobe.incAddr && !strobe.wrWord);

  // R11: no grant, no action
  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !slotGrant |-> !strobe.pop && !strobe.unused && !strobe.markPartial);

endmodule

// File: rtl/wq_datapath.sv
module wq_datapath
  import wq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int CYC_W  = 16,
  parameter int ADDR_W = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CYC_W-1:0]  curCycle,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic [CYC_W-1:0]  pushEligible,
  output logic              pushStall,
  output logic              queueFull,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrValue,
  input  logic [INC_W-1:0]  autoInc,
  input  drainStrobe_t      strobe,
  output logic              headReady,
  output logic              headPartial,
  output logic [ADDR_W-1:0] addr,
  output logic              memWe,
  output logic [1:0]        memTarget,
  output logic              memByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] fillValue
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BYTE_W = DATA_W / 2;
  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slotData  [DEPTH];
  logic [CYC_W-1:0]  slotCycle [DEPTH];
  logic [DEPTH-1:0]  slotPartial;
  logic [DATA_W-1:0] shData    [DEPTH];
  logic [CYC_W-1:0]  shCycle   [DEPTH];
  logic [DEPTH-1:0]  shPartial;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  countNext;
  logic [IDX_W-1:0]  wrIdx;
  logic              pushAccept;

  // shift sources: each slot takes its younger neighbour on a retirement
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i < DEPTH - 1) begin : g_mid
      assign shData[i]    = slotData[i+1];
      assign shCycle[i]   = slotCycle[i+1];
      assign shPartial[i] = slotPartial[i+1];
    end else begin : g_last
      assign shData[i]    = '0;
      assign shCycle[i]   = '0;
      assign shPartial[i] = 1'b0;
    end
  end

  assign queueFull  = (count == FULL_COUNT);
  assign pushStall  = pushValid && queueFull;
  assign pushAccept = pushValid && !queueFull;
  assign wrIdx      = IDX_W'(strobe.pop ? count - CNT_W'(1) : count);
  assign countNext  = CNT_W'(count + CNT_W'(pushAccept) - CNT_W'(strobe.pop));

  assign headReady   = (count != '0) && (slotCycle[0] <= curCycle);
  assign headPartial = slotPartial[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        slotData[i]  <= '0;
        slotCycle[i] <= '0;
      end
      slotPartial <= '0;
      count       <= '0;
    end else begin
      if (strobe.pop) begin
        for (int i = 0; i < DEPTH; i++) begin
          slotData[i]  <= shData[i];
          slotCycle[i] <= shCycle[i];
        end
        slotPartial <= shPartial;
      end else if (strobe.markPartial) begin
        slotPartial[0] <= 1'b1;
      end
      if (pushAccept) begin
        slotData[wrIdx]    <= pushData;
        slotCycle[wrIdx]   <= pushEligible;
        slotPartial[wrIdx] <= 1'b0;
      end
      count <= countNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (addrLoad) begin
      addr <= addrValue;
    end else if (strobe.incAddr) begin
      addr <= ADDR_W'(addr + ADDR_W'(autoInc));
    end
  end

  // memory write port
  assign memWe     = strobe.wrHigh || strobe.wrLow || strobe.wrWord;
  assign memTarget = memWe ? strobe.target : TGT_NONE;
  assign memByte   = strobe.wrHigh || strobe.wrLow;
  assign memAddr   = strobe.wrLow ? (addr ^ ADDR_W'(1)) : addr;
  always_comb begin
    if (strobe.wrHigh)     memData = DATA_W'(slotData[0][DATA_W-1:BYTE_W]);
    else if (strobe.wrLow) memData = DATA_W'(slotData[0][BYTE_W-1:0]);
    else                   memData = slotData[0];
  end
  assign fillValue = slotData[0];

  // R2: occupancy never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_COUNT);

  // R2: a refused push leaves the occupancy alone
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    pushStall && !strobe.pop |=> queueFull);

  // R3: an entry is retired only when it was eligible
  p_pop_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> headReady);

  // R4: the first pattern byte leaves the entry marked as half done
  p_partial_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markPartial |=> headPartial && headReady);

  // R8: the address holds across a fill hand-off
  p_fill_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFill && !addrLoad |=> $stable(addr));

endmodule

// File: rtl/wq_drain.sv
module wq_drain
  import wq_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int DATA_W       = 16,
  parameter int CYC_W        = 16,
  parameter int ADDR_W       = 16,
  parameter int INC_W        = 8,
  parameter int SCROLL_WORDS = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CYC_W-1:0]  curCycle,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic [CYC_W-1:0]  pushEligible,
  output logic              pushStall,
  output logic              queueFull,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrValue,
  input  logic [INC_W-1:0]  autoInc,
  input  logic [3:0]        cmdCode,
  input  logic              dmaReq,
  input  logic              dmaEnable,
  input  logic              slotGrant,
  output logic              memWe,
  output logic [1:0]        memTarget,
  output logic              memByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              fillStart,
  output logic [DATA_W-1:0] fillValue,
  output logic              unusedSlot,
  output logic [ADDR_W-1:0] curAddr
);

  drainStrobe_t            strobe;
  logic                    headReady;
  logic                    headPartial;
  logic [SCROLL_IDX_W-1:0] scrollIdx;

  assign scrollIdx  = curAddr[SCROLL_IDX_W:1];
  assign fillStart  = strobe.startFill;
  assign unusedSlot = strobe.unused;

  wq_ctrl #(
    .SCROLL_WORDS(SCROLL_WORDS)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .slotGrant  (slotGrant),
    .headReady  (headReady),
    .headPartial(headPartial),
    .cmdCode    (cmdCode),
    .dmaEnable  (dmaEnable),
    .dmaReq     (dmaReq),
    .scrollIdx  (scrollIdx),
    .strobe     (strobe)
  );

  wq_datapath #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .CYC_W (CYC_W),
    .ADDR_W(ADDR_W),
    .INC_W (INC_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .curCycle    (curCycle),
    .pushValid   (pushValid),
    .pushData    (pushData),
    .pushEligible(pushEligible),
    .pushStall   (pushStall),
    .queueFull   (queueFull),
    .addrLoad    (addrLoad),
    .addrValue   (addrValue),
    .autoInc     (autoInc),
    .strobe      (strobe),
    .headReady   (headReady),
    .headPartial (headPartial),
    .addr        (curAddr),
    .memWe       (memWe),
    .memTarget   (memTarget),
    .memByte     (memByte),
    .memAddr     (memAddr),
    .memData     (memData),
    .fillValue   (fillValue)
  );

  // R8: a fill hand-off and a memory write never share a slot
  p_fill_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && fillStart));

  // R6: scroll writes only land inside the populated range
  p_scroll_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe && memTarget == 2'd3 |-> int'(scrollIdx) < SCROLL_WORDS);

  // R12: the target field is quiet without a write
  p_target_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !memWe |-> memTarget == 2'd0);

endmodule

// File: tb/tb_wq_drain.sv
module tb_wq_drain;

  localparam int DW = 16;
  localparam int CW = 16;
  localparam int AW = 16;
  localparam int IW = 8;
  localparam int SW = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] curCycle = '0;
  logic          pushValid = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic [CW-1:0] pushEligible = '0;
  logic          pushStall;
  logic          queueFull;
  logic          addrLoad = 1'b0;
  logic [AW-1:0] addrValue = '0;
  logic [IW-1:0] autoInc = '0;
  logic [3:0]    cmdCode = '0;
  logic          dmaReq = 1'b0;
  logic          dmaEnable = 1'b0;
  logic          slotGrant = 1'b0;
  logic          memWe;
  logic [1:0]    memTarget;
  logic          memByte;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic          fillStart;
  logic [DW-1:0] fillValue;
  logic          unusedSlot;
  logic [AW-1:0] curAddr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic          sWe, sByte, sFill, sUnused, sStall;
  logic [1:0]    sTgt;
  logic [AW-1:0] sAddr;
  logic [DW-1:0] sData, sFillVal;

  wq_drain dut (
    .clk(clk), .rstN(rstN), .curCycle(curCycle),
    .pushValid(pushValid), .pushData(pushData), .pushEligible(pushEligible),
    .pushStall(pushStall), .queueFull(queueFull),
    .addrLoad(addrLoad), .addrValue(addrValue), .autoInc(autoInc),
    .cmdCode(cmdCode), .dmaReq(dmaReq), .dmaEnable(dmaEnable),
    .slotGrant(slotGrant), .memWe(memWe), .memTarget(memTarget),
    .memByte(memByte), .memAddr(memAddr), .memData(memData),
    .fillStart(fillStart), .fillValue(fillValue),
    .unusedSlot(unusedSlot), .curAddr(curAddr)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one clock: drive at the falling edge, sample before the rising edge
  task automatic op(bit doPush, logic [DW-1:0] d, logic [CW-1:0] el, bit doGrant);
    @(negedge clk);
    pushValid = doPush; pushData = d; pushEligible = el; slotGrant = doGrant;
    #1;
    sWe = memWe; sTgt = memTarget; sByte = memByte; sAddr = memAddr; sData = memData;
    sFill = fillStart; sFillVal = fillValue; sUnused = unusedSlot; sStall = pushStall;
    @(posedge clk);
    #1;
    pushValid = 1'b0; slotGrant = 1'b0;
  endtask

  task automatic loadAddr(logic [AW-1:0] a);
    @(negedge clk);
    addrLoad = 1'b1; addrValue = a;
    @(posedge clk);
    #1;
    addrLoad = 1'b0;
  endtask

  task automatic expectSlot(string req, bit we, logic [1:0] tgt, bit byteM,
                            logic [AW-1:0] a, logic [DW-1:0] d, bit fill,
                            logic [DW-1:0] fv, bit unused);
    chk(req, "memWe", 32'(sWe), 32'(we));
    chk(req, "memTarget", 32'(sTgt), we ? 32'(tgt) : 32'd0);
    if (we) begin
      chk(req, "memByte", 32'(sByte), 32'(byteM));
      chk(req, "memAddr", 32'(sAddr), 32'(a));
      chk(req, "memData", 32'(sData), 32'(d));
    end
    chk(req, "fillStart", 32'(sFill), 32'(fill));
    if (fill) chk(req, "fillValue", 32'(sFillVal), 32'(fv));
    chk(req, "unusedSlot", 32'(sUnused), 32'(unused));
  endtask

  task automatic expectEmpty(string req);
    op(1'b0, '0, '0, 1'b1);
    expectSlot(req, 1'b0, 2'd0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "queueFull", 32'(queueFull), 0);
    chk("R1", "pushStall", 32'(pushStall), 0);
    chk("R1", "memWe", 32'(memWe), 0);
    chk("R1", "fillStart", 32'(fillStart), 0);
    chk("R1", "unusedSlot", 32'(unusedSlot), 0);
    chk("R1", "curAddr", 32'(curAddr), 0);
    rstN = 1'b1;
    expectEmpty("R1");

    // R2 R9 R5 R10: fill to depth, refuse fifth, drain in order
    cmdCode = 4'd3; autoInc = 8'd2;
    loadAddr(16'h0100);
    for (int k = 0; k < 4; k++) begin
      op(1'b1, 16'hA000 + 16'(k), '0, 1'b0);
      chk("R2", "pushStall", 32'(sStall), 0);
      chk("R2", "queueFull", 32'(queueFull), (k == 3) ? 1 : 0);
    end
    op(1'b1, 16'hBEEF, '0, 1'b0);
    chk("R2", "stall when full", 32'(sStall), 1);
    chk("R2", "still full", 32'(queueFull), 1);
    for (int k = 0; k < 4; k++) begin
      op(1'b0, '0, '0, 1'b1);
      expectSlot("R9", 1'b1, 2'd2, 1'b0, 16'h0100 + 16'(2*k), 16'hA000 + 16'(k), 1'b0, '0, 1'b0);
    end
    chk("R10", "curAddr after 4", 32'(curAddr), 32'h108);
    expectEmpty("R2");

    // R2: push refused even when a retirement shares the cycle
    for (int k = 0; k < 4; k++) op(1'b1, 16'hC000 + 16'(k), '0, 1'b0);
    op(1'b1, 16'hDEAD, '0, 1'b1);
    chk("R2", "stall with pop", 32'(sStall), 1);
    expectSlot("R5", 1'b1, 2'd2, 1'b0, 16'h0108, 16'hC000, 1'b0, '0, 1'b0);
    chk("R2", "not full after pop", 32'(queueFull), 0);
    for (int k = 1; k < 4; k++) begin
      op(1'b0, '0, '0, 1'b1);
      expectSlot("R9", 1'b1, 2'd2, 1'b0, 16'h0108 + 16'(2*k), 16'hC000 + 16'(k), 1'b0, '0, 1'b0);
    end
    expectEmpty("R2");

    // R9: push alongside a retirement keeps order
    op(1'b1, 16'h1111, '0, 1'b0);
    op(1'b1, 16'h2222, '0, 1'b1);
    expectSlot("R9", 1'b1, 2'd2, 1'b0, 16'h0110, 16'h1111, 1'b0, '0, 1'b0);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R9", 1'b1, 2'd2, 1'b0, 16'h0112, 16'h2222, 1'b0, '0, 1'b0);
    expectEmpty("R9");

    // R4 R9: byte pairs for two entries, odd start address
    cmdCode = 4'd1; autoInc = 8'd4;
    loadAddr(16'h0201);
    op(1'b1, 16'h5A3C, '0, 1'b0);
    op(1'b1, 16'h96E1, '0, 1'b0);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R4", 1'b1, 2'd1, 1'b1, 16'h0201, 16'h005A, 1'b0, '0, 1'b0);
    chk("R4", "addr held after high", 32'(curAddr), 32'h201);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R4", 1'b1, 2'd1, 1'b1, 16'h0200, 16'h003C, 1'b0, '0, 1'b0);
    chk("R4", "addr after low", 32'(curAddr), 32'h205);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R9", 1'b1, 2'd1, 1'b1, 16'h0205, 16'h0096, 1'b0, '0, 1'b0);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R9", 1'b1, 2'd1, 1'b1, 16'h0204, 16'h00E1, 1'b0, '0, 1'b0);
    chk("R4", "addr after second", 32'(curAddr), 32'h209);
    expectEmpty("R4");

    // R3: eligibility boundary
    cmdCode = 4'd3; autoInc = 8'd1;
    loadAddr(16'h0300);
    curCycle = 16'd1000;
    op(1'b1, 16'h7777, 16'd1003, 1'b0);
    for (int c = 1000; c < 1003; c++) begin
      curCycle = 16'(c);
      op(1'b0, '0, '0, 1'b1);
      expectSlot("R3", 1'b0, 2'd0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
      chk("R3", "addr held", 32'(curAddr), 32'h300);
    end
    curCycle = 16'd1003;
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R3", 1'b1, 2'd2, 1'b0, 16'h0300, 16'h7777, 1'b0, '0, 1'b0);
    curCycle = 16'd2000;
    op(1'b1, 16'h8888, 16'd1500, 1'b0);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R3", 1'b1, 2'd2, 1'b0, 16'h0301, 16'h8888, 1'b0, '0, 1'b0);
    curCycle = '0;

    // R11: no grant, nothing happens
    loadAddr(16'h0400);
    op(1'b1, 16'h4444, '0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      op(1'b0, '0, '0, 1'b0);
      expectSlot("R11", 1'b0, 2'd0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
      chk("R11", "addr held", 32'(curAddr), 32'h400);
    end
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R11", 1'b1, 2'd2, 1'b0, 16'h0400, 16'h4444, 1'b0, '0, 1'b0);

    // R4 R5 R6 R7 R8 R12: every code, request bit and enable
    for (int de = 0; de < 2; de++) begin
      for (int c = 0; c < 16; c++) begin
        for (int b5 = 0; b5 < 2; b5++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] d;
          logic [IW-1:0] inc;
          bit fillE, inRange;
          a = 16'h0040 + 16'(c*6 + b5*2 + de);
          d = 16'h1234 ^ 16'(c << 8) ^ 16'(b5 << 4) ^ 16'(de);
          inc = IW'(1 + c + 16*b5);
          fillE = (de == 1) && (b5 == 1);
          inRange = ((a >> 1) & 16'h3F) < 16'(SW);
          dmaEnable = de[0]; dmaReq = b5[0]; cmdCode = 4'(c); autoInc = inc;
          loadAddr(a);
          op(1'b1, d, '0, 1'b0);
          op(1'b0, '0, '0, 1'b1);
          if (fillE) begin
            expectSlot("R8", 1'b0, 2'd0, 1'b0, '0, '0, 1'b1, d, 1'b0);
            chk("R8", "addr held", 32'(curAddr), 32'(a));
          end else if (c == 1) begin
            expectSlot("R4", 1'b1, 2'd1, 1'b1, a, 16'(d[15:8]), 1'b0, '0, 1'b0);
            op(1'b0, '0, '0, 1'b1);
            expectSlot("R4", 1'b1, 2'd1, 1'b1, a ^ 16'd1, 16'(d[7:0]), 1'b0, '0, 1'b0);
            chk("R10", "addr step", 32'(curAddr), 32'(16'(a + 16'(inc))));
          end else if (c == 3) begin
            expectSlot("R5", 1'b1, 2'd2, 1'b0, a, d, 1'b0, '0, 1'b0);
            chk("R10", "addr step", 32'(curAddr), 32'(16'(a + 16'(inc))));
          end else if (c == 5) begin
            expectSlot("R6", inRange, 2'd3, 1'b0, a, d, 1'b0, '0, 1'b0);
            chk("R6", "addr step", 32'(curAddr), 32'(16'(a + 16'(inc))));
          end else begin
            expectSlot("R7", 1'b0, 2'd0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
            chk("R7", "addr step", 32'(curAddr), 32'(16'(a + 16'(inc))));
          end
          expectEmpty("R12");
        end
      end
    end
    dmaEnable = 1'b0; dmaReq = 1'b0;

    // R6: scroll range sweep over two wraps of the index
    cmdCode = 4'd5; autoInc = 8'd2;
    loadAddr(16'h0000);
    for (int k = 0; k < 128; k++) begin
      op(1'b1, 16'(16'h6000 + k), '0, 1'b0);
      op(1'b0, '0, '0, 1'b1);
      expectSlot("R6", (k % 64) < SW, 2'd3, 1'b0, 16'(2*k), 16'(16'h6000 + k), 1'b0, '0, 1'b0);
    end
    chk("R6", "addr after sweep", 32'(curAddr), 32'h100);

    // R10: wrap at the top of the address space
    cmdCode = 4'd3; autoInc = 8'd3;
    loadAddr(16'hFFFF);
    op(1'b1, 16'h0F0F, '0, 1'b0);
    op(1'b0, '0, '0, 1'b1);
    expectSlot("R10", 1'b1, 2'd2, 1'b0, 16'hFFFF, 16'h0F0F, 1'b0, '0, 1'b0);
    chk("R10", "wrapped addr", 32'(curAddr), 32'h0002);

    finishRun();
  end

endmodule